// File: doc/BRIEF.md
# Integer Exception Flag Register Unit

This unit keeps the 32-bit integer exception status word that sits beside a 32-bit integer datapath. Each cycle it may receive one instruction's operands, its operation class and its overflow-enable bit. From these it recomputes the overflow, summary-overflow and carry flags from the complete operation. An add or subtract is judged on its whole three-term sum, never on a partial sum. An algebraic right shift produces a carry only when a negative value lost one bits.

Software can write the whole word and read it back through a registered read port. The word includes a 7-bit byte count that a string transfer engine elsewhere consumes, and eight reserved bits that keep whatever is written to them. The flags are also driven straight out, so neighbouring logic can use them without a read. Bit 0 of the architectural numbering is the most significant bit. Below, positions are given in the descending Verilog numbering `[31:0]`.

Top module: `ixr_unit`

## Requirements
- R1: After a synchronous active-high reset, every flag and the byte count are zero, and a read returns 0x00000000.
- R2: In the 32-bit word, summary-overflow sits at [31], overflow at [30] and carry at [29]. Bits [15:8] are the retained reserved field and [6:0] is the byte count. A write of 0xFFFFFFFF therefore reads back as 0xE000FF7F.
- R3: `op_class` is coded as ADD=0, ADDC=1, ADDE=2, SUBF=3, SUBFC=4, SUBFE=5, SRA=6, CMP=7. On any add or subtract class (0 to 5) with `op_oe`=1, overflow becomes the carry out of the top bit XOR the carry into the top bit. With `op_oe`=0, overflow is unchanged.
- R4: Every subtract computes ~a + b + carry-in. The carry-in is 0 for ADD and ADDC, 1 for SUBF and SUBFC, and the stored carry for ADDE and SUBFE. ADDC, ADDE, SUBFC and SUBFE set carry to the carry out of this whole sum. ADD and SUBF leave carry unchanged.
- R5: Summary-overflow becomes 1 whenever an instruction sets overflow to 1. It stays 1 when later instructions clear overflow, and only a software write changes it to 0.
- R6: SRA shifts `op_a` right by `op_b[5:0]`, where an amount of 32 or more discards every bit. Carry becomes 1 only when `op_a` is negative and at least one discarded bit was 1; otherwise carry becomes 0. SRA leaves overflow and summary-overflow unchanged.
- R7: CMP, and any cycle with `op_valid`=0, leave all three flags unchanged.
- R8: Bits [15:8] hold the written value. Bits [28:16] and [7] ignore writes and read as zero.
- R9: A read strobe in one cycle places the word as it stood before that clock edge on `sw_rdata` after the edge. Without a strobe, `sw_rdata` holds its value.
- R10: When a software write and an instruction arrive in the same cycle, the written value applies first and the instruction's update is applied on top of it. The extended classes use the written carry as their carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction result is presented this cycle |
| op_class | input | 3 | Operation class, coded as in R3 |
| op_a | input | 32 | First operand (the inverted one for subtracts, the shift source for SRA) |
| op_b | input | 32 | Second operand; [5:0] is the shift amount for SRA |
| op_oe | input | 1 | Overflow enable for add and subtract classes |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_re | input | 1 | Software read strobe |
| sw_rdata | output | 32 | Registered read data |
| so_o | output | 1 | Summary-overflow flag |
| ov_o | output | 1 | Overflow flag |
| ca_o | output | 1 | Carry flag |

## Verification
A software write and an instruction flag update can land in the same cycle. The bench provokes this by asserting `sw_we` and `op_valid` together. In one case the written carry must feed an extended add. In another, a written summary-overflow must survive an add that clears overflow. In a third, a written zero must be overridden by an overflowing add. Each outcome is judged against the rule that the write applies first: the flag outputs are sampled after the shared edge and must show the instruction's effect layered on the written word.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

    localparam int XLEN    = 32;
    localparam int BCNT_W  = 7;
    localparam int SO_POS  = XLEN - 1;
    localparam int OV_POS  = XLEN - 2;
    localparam int CA_POS  = XLEN - 3;
    localparam int KEEP_HI = XLEN - 17;
    localparam int KEEP_LO = XLEN - 24;
    localparam int KEEP_W  = KEEP_HI - KEEP_LO + 1;
    localparam int SHAMT_W = $clog2(XLEN) + 1;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_ADDC  = 3'd1,
        OPC_ADDE  = 3'd2,
        OPC_SUBF  = 3'd3,
        OPC_SUBFC = 3'd4,
        OPC_SUBFE = 3'd5,
        OPC_SRA   = 3'd6,
        OPC_CMP   = 3'd7
    } ixr_op_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } ixr_flags_t;

    typedef struct packed {
        logic ov_wr;
        logic ov_val;
        logic ca_wr;
        logic ca_val;
    } ixr_upd_t;

    function automatic logic op_is_arith(ixr_op_e op);
        return (op == OPC_ADD)  || (op == OPC_ADDC)  || (op == OPC_ADDE) ||
               (op == OPC_SUBF) || (op == OPC_SUBFC) || (op == OPC_SUBFE);
    endfunction

    function automatic logic op_is_sub(ixr_op_e op);
        return (op == OPC_SUBF) || (op == OPC_SUBFC) || (op == OPC_SUBFE);
    endfunction

    function automatic logic op_writes_carry(ixr_op_e op);
        return (op == OPC_ADDC) || (op == OPC_ADDE) ||
               (op == OPC_SUBFC) || (op == OPC_SUBFE);
    endfunction

    function automatic logic op_carry_in(ixr_op_e op, logic stored_ca);
        logic cin;
        case (op)
            OPC_ADDE, OPC_SUBFE: cin = stored_ca;
            OPC_SUBF, OPC_SUBFC: cin = 1'b1;
            default:             cin = 1'b0;
        endcase
        return cin;
    endfunction

endpackage

// File: rtl/ixr_addsub.sv
module ixr_addsub
    import ixr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  ixr_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           stored_ca,
    output logic           carry_top,
    output logic           ovf
);
    logic [W-1:0] x;
    logic [W-1:0] sum;
    logic         cin;
    logic         carry_into_top;

    always_comb begin
        x   = op_is_sub(op) ? ~a : a;
        cin = op_carry_in(op, stored_ca);
        {carry_top, sum} = {1'b0, x} + {1'b0, b} + {{W{1'b0}}, cin};
        carry_into_top   = x[W-1] ^ b[W-1] ^ sum[W-1];
        ovf              = carry_top ^ carry_into_top;
    end

endmodule

// File: rtl/ixr_sra_carry.sv
module ixr_sra_carry
    import ixr_pkg::*;
#(
    parameter int W = XLEN,
    localparam int AW = $clog2(W) + 1
) (
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] amt,
    output logic          ca
);
    logic [W-1:0] lost_mask;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            lost_mask[i] = (AW'(i) < amt);
        end
        ca = src[W-1] & (|(src & lost_mask));
    end

    // R6: a non-negative source never yields a carry
    always_comb begin
        a_r6_nonneg_no_carry: assert (src[W-1] || !ca);
    end

endmodule

// File: rtl/ixr_store.sv
module ixr_store
    import ixr_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int BW = BCNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    input  logic         sw_re,
    input  ixr_upd_t     upd,
    output logic         base_ca,
    output ixr_flags_t   flags,
    output logic [W-1:0] sw_rdata
);
    localparam int SO_B = W - 1;
    localparam int OV_B = W - 2;
    localparam int CA_B = W - 3;
    localparam int KH   = W - 17;
    localparam int KL   = W - 24;
    localparam int KW   = KH - KL + 1;

    ixr_flags_t    flags_q, base_f, next_f;
    logic [KW-1:0] keep_q, keep_n;
    logic [BW-1:0] bcnt_q, bcnt_n;
    logic [W-1:0]  word;

    always_comb begin
        if (sw_we) begin
            base_f.so = sw_wdata[SO_B];
            base_f.ov = sw_wdata[OV_B];
            base_f.ca = sw_wdata[CA_B];
            keep_n    = sw_wdata[KH:KL];
            bcnt_n    = sw_wdata[BW-1:0];
        end else begin
            base_f = flags_q;
            keep_n = keep_q;
            bcnt_n = bcnt_q;
        end
        base_ca   = base_f.ca;
        next_f.ov = upd.ov_wr ? upd.ov_val : base_f.ov;
        next_f.so = base_f.so | (upd.ov_wr & upd.ov_val);
        next_f.ca = upd.ca_wr ? upd.ca_val : base_f.ca;
    end

    always_comb begin
        word               = '0;
        word[SO_B]         = flags_q.so;
        word[OV_B]         = flags_q.ov;
        word[CA_B]         = flags_q.ca;
        word[KH:KL]        = keep_q;
        word[BW-1:0]       = bcnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            keep_q   <= '0;
            bcnt_q   <= '0;
            sw_rdata <= '0;
        end else begin
            flags_q <= next_f;
            keep_q  <= keep_n;
            bcnt_q  <= bcnt_n;
            if (sw_re) begin
                sw_rdata <= word;
            end
        end
    end

    assign flags = flags_q;

    // R5: summary-overflow never drops without a software write
    a_r5_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.so && !sw_we) |=> flags_q.so);

    // R9: read data holds without a strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !sw_re |=> $stable(sw_rdata));

    // R8: unretained reserved bits read as zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sw_rdata[W-4:W-16] == '0) && (sw_rdata[BW] == 1'b0));

endmodule

// File: rtl/ixr_unit.sv
module ixr_unit
    import ixr_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int BW = BCNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [2:0]   op_class,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_oe,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    input  logic         sw_re,
    output logic [W-1:0] sw_rdata,
    output logic         so_o,
    output logic         ov_o,
    output logic         ca_o
);
    localparam int AW = $clog2(W) + 1;

    ixr_op_e    op;
    ixr_upd_t   upd;
    ixr_flags_t flags;
    logic       base_ca;
    logic       arith_carry, arith_ovf, sra_ca;

    assign op = ixr_op_e'(op_class);

    ixr_addsub #(.W(W)) u_addsub (
        .op        (op),
        .a         (op_a),
        .b         (op_b),
        .stored_ca (base_ca),
        .carry_top (arith_carry),
        .ovf       (arith_ovf)
    );

    ixr_sra_carry #(.W(W)) u_sra (
        .src (op_a),
        .amt (op_b[AW-1:0]),
        .ca  (sra_ca)
    );

    always_comb begin
        upd = '0;
        if (op_valid) begin
            if (op_is_arith(op) && op_oe) begin
                upd.ov_wr  = 1'b1;
                upd.ov_val = arith_ovf;
            end
            if (op_writes_carry(op)) begin
                upd.ca_wr  = 1'b1;
                upd.ca_val = arith_carry;
            end else if (op == OPC_SRA) begin
                upd.ca_wr  = 1'b1;
                upd.ca_val = sra_ca;
            end
        end
    end

    ixr_store #(.W(W), .BW(BW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .sw_re    (sw_re),
        .upd      (upd),
        .base_ca  (base_ca),
        .flags    (flags),
        .sw_rdata (sw_rdata)
    );

    assign so_o = flags.so;
    assign ov_o = flags.ov;
    assign ca_o = flags.ca;

    // R7: a compare leaves every flag as it was
    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 3'd7 && !sw_we) |=> $stable({so_o, ov_o, ca_o}));

    // R3: overflow disabled keeps the overflow flag
    a_r3_oe_off_hold: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_oe && !sw_we) |=> $stable(ov_o));

endmodule

// File: tb/ixr_unit_tb.sv
module ixr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_class;
    logic [31:0] op_a, op_b;
    logic        op_oe;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic        sw_re;
    logic [31:0] sw_rdata;
    logic        so_o, ov_o, ca_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ixr_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
        .op_a(op_a), .op_b(op_b), .op_oe(op_oe), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .sw_re(sw_re), .sw_rdata(sw_rdata),
        .so_o(so_o), .ov_o(ov_o), .ca_o(ca_o)
    );

    typedef struct packed {
        logic [2:0]  cls;
        logic [31:0] a;
        logic [31:0] b;
        logic        oe;
        logic [2:0]  pre;
        logic [2:0]  expf;
    } vec_t;

    localparam int NV = 17;
    // flag triples are {so, ov, ca}
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 3'b000, 3'b110}, // R3 R5 add overflow
        '{3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 3'b000, 3'b000}, // R3 oe off
        '{3'd1, 32'hFFFFFFFF, 32'h00000001, 1'b1, 3'b000, 3'b001}, // R4 addc carry, no ov
        '{3'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 3'b001, 3'b001}, // R4 adde uses stored ca
        '{3'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 3'b000, 3'b000}, // R4 adde ca 0
        '{3'd4, 32'h00000001, 32'h00000001, 1'b1, 3'b000, 3'b001}, // R4 subfc carry
        '{3'd4, 32'h00000002, 32'h00000001, 1'b0, 3'b001, 3'b000}, // R4 subfc borrow
        '{3'd5, 32'h00000000, 32'h00000000, 1'b0, 3'b010, 3'b010}, // R4 subfe ca 0
        '{3'd5, 32'h00000000, 32'h00000000, 1'b0, 3'b001, 3'b001}, // R4 subfe whole sum
        '{3'd3, 32'h00000001, 32'h80000000, 1'b1, 3'b000, 3'b110}, // R3 R4 subf ovf, ca kept
        '{3'd6, 32'h80000001, 32'h00000001, 1'b0, 3'b000, 3'b001}, // R6 neg lost one
        '{3'd6, 32'h80000000, 32'h00000004, 1'b0, 3'b001, 3'b000}, // R6 neg lost zeros
        '{3'd6, 32'h00000001, 32'h00000001, 1'b0, 3'b001, 3'b000}, // R6 positive
        '{3'd6, 32'hFFFFFFFF, 32'h00000028, 1'b0, 3'b000, 3'b001}, // R6 amount >= 32
        '{3'd6, 32'h80000000, 32'h00000000, 1'b0, 3'b001, 3'b000}, // R6 amount 0
        '{3'd7, 32'h7FFFFFFF, 32'h00000001, 1'b1, 3'b111, 3'b111}, // R7 compare
        '{3'd0, 32'h00000001, 32'h00000001, 1'b1, 3'b110, 3'b100}  // R5 ov cleared, so kept
    };

    task automatic step();
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        sw_we    = 1'b0;
        sw_re    = 1'b0;
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_we = 1'b1; sw_wdata = d;
        step();
    endtask

    task automatic issue(input logic [2:0] c, input logic [31:0] a,
                         input logic [31:0] b, input logic oe);
        op_valid = 1'b1; op_class = c; op_a = a; op_b = b; op_oe = oe;
    endtask

    task automatic sw_read(output logic [31:0] d);
        sw_re = 1'b1;
        step();
        d = sw_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; op_valid = 1'b0; op_class = 3'd0; op_a = '0; op_b = '0;
        op_oe = 1'b0; sw_we = 1'b0; sw_wdata = '0; sw_re = 1'b0;
        #1;
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        chk("R1 flags", {29'd0, so_o, ov_o, ca_o}, 32'd0);
        sw_read(rd);
        chk("R1 read", rd, 32'd0);

        // vector table: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            sw_write({VECS[i].pre, 29'd0});
            issue(VECS[i].cls, VECS[i].a, VECS[i].b, VECS[i].oe);
            step();
            chk($sformatf("R3/R4/R5/R6/R7 vector %0d", i),
                {29'd0, so_o, ov_o, ca_o}, {29'd0, VECS[i].expf});
        end

        // R2 R8 field layout and reserved bits
        sw_write(32'hFFFFFFFF);
        sw_read(rd);
        chk("R2 R8 all ones", rd, 32'hE000FF7F);
        sw_write(32'h1FFF0080);
        sw_read(rd);
        chk("R8 zero bits ignore writes", rd, 32'h00000000);
        sw_write(32'h0000A555);
        sw_read(rd);
        chk("R2 R8 keep and count", rd, 32'h0000A555);

        // R5 sticky across several instructions, cleared by write
        sw_write(32'h0);
        issue(3'd0, 32'h7FFFFFFF, 32'h1, 1'b1); step();
        issue(3'd0, 32'h1, 32'h1, 1'b1); step();
        issue(3'd1, 32'h2, 32'h3, 1'b1); step();
        issue(3'd6, 32'h4, 32'h1, 1'b0); step();
        chk("R5 so sticky", {29'd0, so_o, ov_o, ca_o}, 32'h4);
        sw_write(32'h0);
        chk("R5 so cleared by write", {31'd0, so_o}, 32'd0);

        // R9 read latency and hold
        sw_write(32'h20000011);
        sw_read(rd);
        chk("R9 read after strobe", rd, 32'h20000011);
        sw_write(32'h00000022);
        step();
        chk("R9 hold without strobe", sw_rdata, 32'h20000011);
        sw_read(rd);
        chk("R9 new read", rd, 32'h00000022);

        // R10 write and instruction in the same cycle
        sw_we = 1'b1; sw_wdata = 32'h20000000;
        issue(3'd2, 32'hFFFFFFFF, 32'h0, 1'b0); step();
        chk("R10 written carry feeds adde", {29'd0, so_o, ov_o, ca_o}, 32'h1);
        sw_we = 1'b1; sw_wdata = 32'hC0000000;
        issue(3'd0, 32'h1, 32'h1, 1'b1); step();
        chk("R10 written so kept, ov cleared", {29'd0, so_o, ov_o, ca_o}, 32'h4);
        sw_we = 1'b1; sw_wdata = 32'h00000000;
        issue(3'd0, 32'h7FFFFFFF, 32'h1, 1'b1); step();
        chk("R10 overflow over written zero", {29'd0, so_o, ov_o, ca_o}, 32'h6);

        // R1 reset again clears everything
        sw_write(32'hFFFFFFFF);
        rst = 1'b1; step(); rst = 1'b0;
        sw_read(rd);
        chk("R1 reset clears word", rd, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule